// File: doc/BRIEF.md
# Write Protection Command Sequencer

This block sits beside the page-load controller of an electrically erasable memory and watches every byte write offered to it (a low address and a data byte). It recognises two unlock sequences written to fixed command addresses: a three-write sequence that turns software write protection on, and a six-write sequence that turns it off. From what it sees it reports whether protection is active, whether the current load period may commit data to the array, and which individual write beats are command bytes that must not be stored.

A protection change never takes effect at the moment the sequence completes. It waits for the end-of-write-cycle pulse from the page controller that closes the same load period. While protection is on, a load period may commit only if it opens with the three-write prefix. A protected write without that prefix still goes to the page controller, which runs its timed busy period, but the commit flag stays low so nothing is stored. A power-up hold-off counter, released by a power-good input, keeps writes out until a programmable number of cycles has elapsed.

The write stream uses a valid/ready handshake. A beat is accepted in a cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` is low during the power-up hold-off. A producer facing a low `wr_ready` either holds its beat or drops it; the block never records a beat that was not accepted. `swallow` is a combinational flag that is valid in the cycle of the accepted beat.

Top module: `wp_cmd_seq`

## Requirements
- R1: After reset, `protect` is 0, `commit_ok` is 1, `swallow` is 0 and `wr_ready` is 0.
- R2: `wr_ready` is 1 only while `pwr_good` is 1 and has been sampled high on `HOLD_CYCLES` consecutive clock edges. It drops in the same cycle that `pwr_good` goes low.
- R3: The lock sequence is three accepted beats with (address, data): (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0xA0). Each of these beats raises `swallow`. `protect` becomes 1 in the cycle after the next `cycle_done` pulse.
- R4: The unlock sequence is six accepted beats: (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0x80), (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0x20). Each of these beats raises `swallow`. `protect` becomes 0 in the cycle after the next `cycle_done` pulse.
- R5: `protect` changes only in the cycle after a `cycle_done` pulse.
- R6: While `protect` is 1 and no sequence has completed in the current load period, `commit_ok` is 0 and ordinary write beats are not swallowed.
- R7: A completed lock or unlock sequence raises `commit_ok` from the next cycle until the cycle after `cycle_done`. While `protect` is 0, `commit_ok` is always 1.
- R8: An accepted beat that does not match the expected step returns the matcher to its first step. That beat is not swallowed, and the sequence must start again with (0x5555, 0xAA).
- R9: A beat accepted while `pg_busy` is 1 is never swallowed and returns the matcher to its first step.
- R10: After a sequence completes, every further beat in the same load period is treated as data and not swallowed, even if it matches a command step.
- R11: `protect` keeps its value while `pwr_good` is low. Only `rst_n` or an unlock sequence clears it.
- R12: `swallow` is 1 only in a cycle where a beat is accepted and `pg_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_good | input | 1 | Supply-good indication from power supervision |
| wr_valid | input | 1 | A write beat is offered |
| wr_ready | output | 1 | The block accepts write beats (hold-off elapsed) |
| wr_addr | input | ADDR_W (15) | Low address of the write beat |
| wr_data | input | DATA_W (8) | Data byte of the write beat |
| pg_busy | input | 1 | Page controller is in its timed write cycle |
| cycle_done | input | 1 | One-cycle pulse at the end of a write cycle |
| protect | output | 1 | Software write protection is active |
| commit_ok | output | 1 | The current load period may store data |
| swallow | output | 1 | The current accepted beat is a command byte; do not store it |

## Verification
The bench drives the lock sequence followed by ordinary data, the full unlock sequence, and a protected write with no prefix. These patterns separate a correct matcher from one that swallows too much or too little, and show whether the protect flag is applied at the cycle-end pulse or too early. It also drives sequences broken at the second step and at the fourth step, command-like beats sent after a completed prefix, and command beats sent while the page controller is busy. These patterns expose a matcher that fails to return to its first step, or that keeps matching after a sequence has completed. A power-good drop in the middle of the run checks both the hold-off timing and that protection survives the drop. A reference model compares all four outputs with the design on every cycle.

// File: rtl/wpcs_pkg.sv
package wpcs_pkg;

  typedef enum logic [2:0] {
    STP_0    = 3'd0,
    STP_1    = 3'd1,
    STP_2    = 3'd2,
    STP_3    = 3'd3,
    STP_4    = 3'd4,
    STP_5    = 3'd5,
    STP_DONE = 3'd6
  } step_e;

  typedef enum logic [1:0] {
    HIT_NONE   = 2'd0,
    HIT_STEP   = 2'd1,
    HIT_LOCK   = 2'd2,
    HIT_UNLOCK = 2'd3
  } hit_e;

  localparam int unsigned NUM_STEPS = 6;

endpackage

// File: rtl/wpcs_holdoff.sv
module wpcs_holdoff #(
  parameter int unsigned HOLD_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  output logic ready
);
  localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HOLD_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !pwr_good) begin
      cnt_q <= '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ready = pwr_good && (cnt_q == CNT_MAX);
endmodule

// File: rtl/wpcs_matcher.sv
module wpcs_matcher
  import wpcs_pkg::*;
#(
  parameter int unsigned     ADDR_W      = 15,
  parameter int unsigned     DATA_W      = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR_A = 15'h5555,
  parameter logic [ADDR_W-1:0] CMD_ADDR_B = 15'h2AAA,
  parameter logic [DATA_W-1:0] KEY_LEAD0  = 8'hAA,
  parameter logic [DATA_W-1:0] KEY_LEAD1  = 8'h55,
  parameter logic [DATA_W-1:0] KEY_LOCK   = 8'hA0,
  parameter logic [DATA_W-1:0] KEY_MID    = 8'h80,
  parameter logic [DATA_W-1:0] KEY_UNLOCK = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic              busy,
  input  logic              cycle_done,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output hit_e              hit
);
  localparam logic [ADDR_W-1:0] STEP_ADDR [NUM_STEPS] =
    '{CMD_ADDR_A, CMD_ADDR_B, CMD_ADDR_A, CMD_ADDR_A, CMD_ADDR_B, CMD_ADDR_A};
  localparam logic [DATA_W-1:0] STEP_DATA [NUM_STEPS] =
    '{KEY_LEAD0, KEY_LEAD1, KEY_LOCK, KEY_LEAD0, KEY_LEAD1, KEY_UNLOCK};

  step_e               st_q;
  step_e               st_d;
  logic [NUM_STEPS-1:0] step_hit;
  logic                mid_hit;

  // one address/data comparator per sequence step
  for (genvar i = 0; i < NUM_STEPS; i++) begin : g_cmp
    assign step_hit[i] = (addr == STEP_ADDR[i]) && (data == STEP_DATA[i]);
  end
  assign mid_hit = (addr == CMD_ADDR_A) && (data == KEY_MID);

  always_comb begin
    hit = HIT_NONE;
    if (beat && !busy) begin
      unique case (st_q)
        STP_0: if (step_hit[0]) hit = HIT_STEP;
        STP_1: if (step_hit[1]) hit = HIT_STEP;
        STP_2: begin
          if (step_hit[2])  hit = HIT_LOCK;
          else if (mid_hit) hit = HIT_STEP;
        end
        STP_3: if (step_hit[3]) hit = HIT_STEP;
        STP_4: if (step_hit[4]) hit = HIT_STEP;
        STP_5: if (step_hit[5]) hit = HIT_UNLOCK;
        default: hit = HIT_NONE;
      endcase
    end
  end

  always_comb begin
    st_d = st_q;
    if (cycle_done) begin
      st_d = STP_0;
    end else if (beat) begin
      unique case (hit)
        HIT_STEP:   st_d = step_e'(st_q + 3'd1);
        HIT_LOCK,
        HIT_UNLOCK: st_d = STP_DONE;
        default:    if (st_q != STP_DONE) st_d = STP_0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= STP_0;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/wpcs_state.sv
module wpcs_state
  import wpcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  hit_e hit,
  input  logic cycle_done,
  output logic protect,
  output logic commit_ok
);
  logic prot_q;
  logic open_q;
  logic pend_lock_q;
  logic pend_unlock_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prot_q        <= 1'b0;
      open_q        <= 1'b0;
      pend_lock_q   <= 1'b0;
      pend_unlock_q <= 1'b0;
    end else if (cycle_done) begin
      if (pend_lock_q)        prot_q <= 1'b1;
      else if (pend_unlock_q) prot_q <= 1'b0;
      open_q        <= 1'b0;
      pend_lock_q   <= 1'b0;
      pend_unlock_q <= 1'b0;
    end else if (hit == HIT_LOCK) begin
      open_q        <= 1'b1;
      pend_lock_q   <= 1'b1;
      pend_unlock_q <= 1'b0;
    end else if (hit == HIT_UNLOCK) begin
      open_q        <= 1'b1;
      pend_lock_q   <= 1'b0;
      pend_unlock_q <= 1'b1;
    end
  end

  assign protect   = prot_q;
  assign commit_ok = !prot_q || open_q;
endmodule

// File: rtl/wp_cmd_seq.sv
module wp_cmd_seq
  import wpcs_pkg::*;
#(
  parameter int unsigned ADDR_W      = 15,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned HOLD_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pg_busy,
  input  logic              cycle_done,
  output logic              protect,
  output logic              commit_ok,
  output logic              swallow
);
  logic beat;
  hit_e hit;

  wpcs_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) u_holdoff (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_good (pwr_good),
    .ready    (wr_ready)
  );

  assign beat = wr_valid && wr_ready;

  wpcs_matcher #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_matcher (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat       (beat),
    .busy       (pg_busy),
    .cycle_done (cycle_done),
    .addr       (wr_addr),
    .data       (wr_data),
    .hit        (hit)
  );

  wpcs_state u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit        (hit),
    .cycle_done (cycle_done),
    .protect    (protect),
    .commit_ok  (commit_ok)
  );

  assign swallow = (hit != HIT_NONE);
endmodule

// File: rtl/wp_cmd_seq_chk.sv
module wp_cmd_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_good,
  input logic wr_valid,
  input logic wr_ready,
  input logic pg_busy,
  input logic cycle_done,
  input logic protect,
  input logic commit_ok,
  input logic swallow
);
  AST_SWALLOW_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    swallow |-> (wr_valid && wr_ready && !pg_busy)); // R12

  AST_PROTECT_AT_CYCLE_END: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_done |=> $stable(protect)); // R5

  AST_READY_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> pwr_good); // R2

  AST_OPEN_WHEN_UNPROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !protect |-> commit_ok); // R7

  AST_PROTECT_SURVIVES_POWER: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_good && !cycle_done) |=> $stable(protect)); // R11
endmodule

bind wp_cmd_seq wp_cmd_seq_chk u_chk (.*);

// File: tb/wp_cmd_seq_tb.sv
module wp_cmd_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_good = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        pg_busy = 1'b0;
  logic        cycle_done = 1'b0;
  logic        protect;
  logic        commit_ok;
  logic        swallow;

  int    n_chk = 0;
  int    n_err = 0;
  string cur_req = "R1";

  // reference model state
  int m_hold = 0;
  int m_step = 0;   // 0..5 = awaiting step, 6 = sequence complete
  bit m_prot = 0, m_open = 0, m_plock = 0, m_punlock = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wp_cmd_seq #(.HOLD_CYCLES(HOLD)) u_dut (.*);

  function automatic bit m_ready();
    return pwr_good && (m_hold >= HOLD);
  endfunction

  // 0 none, 1 advance, 2 lock complete, 3 unlock complete
  function automatic int m_hit();
    if (!(wr_valid && m_ready()) || pg_busy) return 0;
    case (m_step)
      0: return (wr_addr == 15'h5555 && wr_data == 8'hAA) ? 1 : 0;
      1: return (wr_addr == 15'h2AAA && wr_data == 8'h55) ? 1 : 0;
      2: begin
        if (wr_addr == 15'h5555 && wr_data == 8'hA0) return 2;
        if (wr_addr == 15'h5555 && wr_data == 8'h80) return 1;
        return 0;
      end
      3: return (wr_addr == 15'h5555 && wr_data == 8'hAA) ? 1 : 0;
      4: return (wr_addr == 15'h2AAA && wr_data == 8'h55) ? 1 : 0;
      5: return (wr_addr == 15'h5555 && wr_data == 8'h20) ? 3 : 0;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hold = 0; m_step = 0; m_prot = 0; m_open = 0; m_plock = 0; m_punlock = 0;
    end else begin
      int h;
      h = m_hit();
      if (cycle_done) begin
        if (m_plock) m_prot = 1;
        else if (m_punlock) m_prot = 0;
        m_open = 0; m_plock = 0; m_punlock = 0; m_step = 0;
      end else if (wr_valid && m_ready()) begin
        if (h == 1) m_step = m_step + 1;
        else if (h == 2) begin m_open = 1; m_plock = 1; m_punlock = 0; m_step = 6; end
        else if (h == 3) begin m_open = 1; m_punlock = 1; m_plock = 0; m_step = 6; end
        else if (m_step != 6) m_step = 0;
      end
      if (!pwr_good) m_hold = 0;
      else if (m_hold < HOLD) m_hold = m_hold + 1;
    end
  end

  task automatic check(string req, string name, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, name, act, exp, $time);
    end
  endtask

  // compare every cycle, between the driving edge and the next rising edge
  always begin
    @(negedge clk);
    #2;
    check(cur_req, "wr_ready",  wr_ready,  m_ready());
    check(cur_req, "protect",   protect,   m_prot);
    check(cur_req, "commit_ok", commit_ok, !m_prot || m_open);
    check(cur_req, "swallow",   swallow,   m_hit() != 0);
  end

  task automatic beat(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic end_cycle();
    @(negedge clk); pg_busy = 1'b1;
    repeat (3) @(negedge clk);
    cycle_done = 1'b1;
    @(negedge clk); cycle_done = 1'b0; pg_busy = 1'b0;
    @(negedge clk);
  endtask

  task automatic lock_prefix();
    beat(15'h5555, 8'hAA); beat(15'h2AAA, 8'h55); beat(15'h5555, 8'hA0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    #2 check("R1", "reset protect", protect, 1'b0);
    check("R1", "reset commit_ok", commit_ok, 1'b1);
    check("R1", "reset wr_ready", wr_ready, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    cur_req = "R2";
    @(negedge clk); pwr_good = 1'b1;
    beat(15'h5555, 8'hAA);              // offered during hold-off: not accepted
    repeat (HOLD + 2) @(negedge clk);
    #2 check("R2", "ready after hold-off", wr_ready, 1'b1);

    cur_req = "R7";
    beat(15'h0123, 8'h5A);             // unprotected plain write
    end_cycle();

    cur_req = "R3";
    lock_prefix();
    beat(15'h0100, 8'h77);
    end_cycle();
    #2 check("R3", "protect after lock", protect, 1'b1);

    cur_req = "R6";
    beat(15'h0010, 8'h11);
    #2 check("R6", "commit blocked", commit_ok, 1'b0);
    end_cycle();

    cur_req = "R10";
    lock_prefix();
    #2 check("R7", "commit after prefix", commit_ok, 1'b1);
    beat(15'h5555, 8'hAA);
    beat(15'h2AAA, 8'h55);
    end_cycle();

    cur_req = "R8";
    beat(15'h5555, 8'hAA); beat(15'h2AAA, 8'h56); beat(15'h5555, 8'hA0);
    beat(15'h5555, 8'hAA); beat(15'h2AAA, 8'h55); beat(15'h5555, 8'h80);
    beat(15'h2AAA, 8'hAA);               // breaks unlock at its fourth step
    beat(15'h5555, 8'hAA);
    end_cycle();
    #2 check("R8", "still protected", protect, 1'b1);

    cur_req = "R9";
    @(negedge clk); pg_busy = 1'b1;
    beat(15'h5555, 8'hAA);
    @(negedge clk); pg_busy = 1'b0;
    beat(15'h2AAA, 8'h55); beat(15'h5555, 8'hA0);
    @(negedge clk); cycle_done = 1'b1;
    @(negedge clk); cycle_done = 1'b0;

    cur_req = "R11";
    @(negedge clk); pwr_good = 1'b0;
    beat(15'h5555, 8'hAA);
    repeat (4) @(negedge clk);
    #2 check("R11", "protect kept", protect, 1'b1);
    @(negedge clk); pwr_good = 1'b1;
    repeat (HOLD + 2) @(negedge clk);

    cur_req = "R4";
    beat(15'h5555, 8'hAA); beat(15'h2AAA, 8'h55); beat(15'h5555, 8'h80);
    beat(15'h5555, 8'hAA); beat(15'h2AAA, 8'h55); beat(15'h5555, 8'h20);
    #2 check("R5", "protect held before cycle end", protect, 1'b1);
    beat(15'h0200, 8'h33);
    end_cycle();
    #2 check("R4", "protect after unlock", protect, 1'b0);

    cur_req = "R12";
    beat(15'h0300, 8'h44);
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule